// File: doc/BRIEF.md
# Two-Step Flash Conversion Sequencer

This block is the digital controller of an 8-bit two-step flash converter. One bank of fifteen comparators is used twice per conversion. In the first pass the bank compares the held input against the coarse ladder. The sequencer encodes that thermometer word to the upper nibble and presents the nibble on a select port that drives the residue DAC. In the second pass the same comparators see the residue, and the sequencer encodes them again to form the lower nibble. Each pass lasts a fixed, parameterised number of clock cycles, which stands in for the analog settling delay.

A host reaches the block through active-low chip-select, read and write strobes and drives its 8-bit tri-state data bus. A mode input picks one of two sequences. With the mode low, a falling read strobe starts the conversion, and an open-drain wait output holds the host off until the result is ready. With the mode high, the conversion runs on a write pulse and is read back later. The host may wait for the interrupt output, or issue an early read that ends the second pass at once. With chip-select and read tied low, this mode also runs stand-alone.

Top module: `hfs_top`

## Requirements
- R1: After reset `irq_n` is 1, `wait_pull` is 0, `dac_en` is 0 and `bus_oe` is 0 while `cs_n` is high.
- R2: Each pass encodes the 15-bit thermometer word as the count of its ones, so a non-monotonic (bubbled) word still gives the code equal to that count.
- R3: The result is {first-pass code, second-pass code}, upper nibble in bits 7:4. During the second pass `dac_en` is 1 and `dac_code` holds the first-pass code unchanged.
- R4: With `wrrd_mode` = 0, a falling `rd_n` while `cs_n` is low starts a conversion, and `irq_n` is first seen low 2*PASS_CYC+1 cycles after the strobe is driven. A write pulse in this mode, or any strobe while `cs_n` is high, starts nothing.
- R5: With `wrrd_mode` = 0, `wait_pull` is 1 from the cycle after `cs_n` falls until `irq_n` falls, and it is 0 in the cycle where `irq_n` first reads low.
- R6: With `wrrd_mode` = 1, a falling `wr_n` with `cs_n` low starts the first pass. The sequencer then holds (`dac_en` 0, `irq_n` 1) until `wr_n` is high. The second pass of PASS_CYC cycles follows, and `irq_n` is first seen low PASS_CYC+1 cycles after `wr_n` is driven high.
- R7: With `wrrd_mode` = 1, a falling `rd_n` with `cs_n` low during the second pass completes the conversion at once: `irq_n` reads low one cycle later, and the bus carries the full result.
- R8: `irq_n` returns to 1 on a rising `rd_n` or a rising `cs_n`, and also when a new conversion starts.
- R9: `bus_oe` is 1, and `bus_io` is driven with the result register, only while `cs_n` and `rd_n` are both low. In read mode it stays 0 during a conversion. Otherwise `bus_io` is high-impedance.
- R10: With `wrrd_mode` = 1 and `cs_n` = `rd_n` = 0, each falling `wr_n` starts a conversion. The bus keeps the previous result from that falling edge until `wr_n` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrrd_mode | input | 1 | 0 = read-strobe sequence, 1 = write-then-read sequence |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| therm | input | 15 | Comparator bank thermometer outputs |
| dac_code | output | 4 | Upper nibble sent to the residue DAC |
| dac_en | output | 1 | Comparators see the residue (second pass) |
| irq_n | output | 1 | End-of-conversion flag, active low |
| wait_pull | output | 1 | 1 = open-drain wait line pulled low |
| bus_oe | output | 1 | Data bus driven |
| bus_io | inout | 8 | Tri-state result bus |

## Verification
The comparator model in the bench derives the thermometer word from a held input value and from `dac_code`/`dac_en`. Conversions of all-zero and all-one inputs and of mixed codes such as 0xA5 and 0x3C check that the nibbles are split and ordered correctly. Bubbled thermometer words check that the count of ones, not the top set bit, sets each code. Each sequence (read strobe, write then wait for the interrupt, write then early read, stand-alone write pulses) uses a different start and completion path. Pulses that must be ignored separate a real start from the mode and chip-select gating.

// File: rtl/hfs_pkg.sv
package hfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COARSE = 2'd1,
    ST_WAIT   = 2'd2,
    ST_FINE   = 2'd3
  } hfs_state_e;
endpackage

// File: rtl/hfs_therm_enc.sv
module hfs_therm_enc #(
  parameter int NLEV = 15,
  localparam int CW = $clog2(NLEV + 1)
) (
  input  logic [NLEV-1:0] therm,
  output logic [CW-1:0]   code
);
  // Count of ones: tolerant of bubbles in the thermometer word.
  always_comb begin
    code = '0;
    for (int i = 0; i < NLEV; i++) begin
      code = code + {{(CW-1){1'b0}}, therm[i]};
    end
  end
endmodule

// File: rtl/hfs_pass_timer.sv
module hfs_pass_timer #(
  parameter int PASS_CYC = 4,
  localparam int TW = (PASS_CYC > 1) ? $clog2(PASS_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic done
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)  cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == TW'(PASS_CYC - 1));
endmodule

// File: rtl/hfs_ctrl.sv
module hfs_ctrl
  import hfs_pkg::*;
#(
  parameter int NIB = 4,
  localparam int RW = 2 * NIB
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wrrd_mode,
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [NIB-1:0] nib_code,
  input  logic           pass_done,
  output logic           tmr_restart,
  output logic           tmr_run,
  output logic [NIB-1:0] dac_code,
  output logic           dac_en,
  output logic [RW-1:0]  result,
  output logic           irq_n,
  output logic           wait_pull,
  output logic           bus_oe
);
  hfs_state_e     st_q, st_d;
  logic [NIB-1:0] hi_q, hi_d;
  logic [RW-1:0]  res_q, res_d;
  logic           irq_q, irq_d;
  logic           busy_q, busy_d;
  logic           cs_q, rd_q, wr_q;
  logic           cs_fall, cs_rise, rd_fall, rd_rise, wr_fall;
  logic           start;

  assign cs_fall = cs_q & ~cs_n;
  assign cs_rise = ~cs_q & cs_n;
  assign rd_fall = rd_q & ~rd_n;
  assign rd_rise = ~rd_q & rd_n;
  assign wr_fall = wr_q & ~wr_n;
  assign start   = ~cs_n & ((~wrrd_mode & rd_fall) | (wrrd_mode & wr_fall));

  always_comb begin
    st_d        = st_q;
    hi_d        = hi_q;
    res_d       = res_q;
    irq_d       = irq_q;
    busy_d      = busy_q;
    tmr_restart = 1'b0;
    tmr_run     = 1'b0;
    if (cs_rise | rd_rise) irq_d = 1'b1;
    if (~wrrd_mode & cs_fall) busy_d = 1'b1;
    if (cs_rise) busy_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d        = ST_COARSE;
          tmr_restart = 1'b1;
          irq_d       = 1'b1;
        end
      end
      ST_COARSE: begin
        tmr_run = 1'b1;
        if (pass_done) begin
          hi_d = nib_code;
          if (wrrd_mode && !wr_n) begin
            st_d = ST_WAIT;
          end else begin
            st_d        = ST_FINE;
            tmr_restart = 1'b1;
            if (wrrd_mode) res_d[RW-1:NIB] = nib_code;
          end
        end
      end
      ST_WAIT: begin
        if (wr_n) begin
          st_d            = ST_FINE;
          tmr_restart     = 1'b1;
          res_d[RW-1:NIB] = hi_q;
        end
      end
      ST_FINE: begin
        tmr_run = 1'b1;
        if ((wrrd_mode && rd_fall && !cs_n) || pass_done) begin
          res_d  = {hi_q, nib_code};
          irq_d  = 1'b0;
          busy_d = 1'b0;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hi_q   <= '0;
      res_q  <= '0;
      irq_q  <= 1'b1;
      busy_q <= 1'b0;
      cs_q   <= 1'b1;
      rd_q   <= 1'b1;
      wr_q   <= 1'b1;
    end else begin
      st_q   <= st_d;
      hi_q   <= hi_d;
      res_q  <= res_d;
      irq_q  <= irq_d;
      busy_q <= busy_d;
      cs_q   <= cs_n;
      rd_q   <= rd_n;
      wr_q   <= wr_n;
    end
  end

  assign dac_code  = hi_q;
  assign dac_en    = (st_q == ST_FINE);
  assign result    = res_q;
  assign irq_n     = irq_q;
  assign wait_pull = busy_q;
  assign bus_oe    = ~cs_n & ~rd_n & (wrrd_mode | (st_q == ST_IDLE));

  // R3: residue select stays put through the second pass
  a_r3_dac_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FINE && $past(st_q) == ST_FINE) |-> $stable(hi_q));
  // R4: idle read mode with read high stays idle
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !wrrd_mode && rd_n) |=> (st_q == ST_IDLE));
  // R5: wait line released when conversion ends in read mode
  a_r5_wait_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(irq_q) && !wrrd_mode) |-> !busy_q);
  // R6: sequencer holds while write strobe is low after first pass
  a_r6_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !wr_n) |=> (st_q == ST_WAIT));
  // R7: early read ends second pass
  a_r7_early_read: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FINE && wrrd_mode && $fell(rd_n) && !cs_n) |=> (!irq_q && st_q == ST_IDLE));
  // R8: rising chip select releases the interrupt
  a_r8_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n) && st_q == ST_IDLE) |=> irq_q);
endmodule

// File: rtl/hfs_top.sv
module hfs_top #(
  parameter int NIB      = 4,
  parameter int PASS_CYC = 4,
  localparam int NLEV = (1 << NIB) - 1,
  localparam int RW   = 2 * NIB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wrrd_mode,
  input  logic            cs_n,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic [NLEV-1:0] therm,
  output logic [NIB-1:0]  dac_code,
  output logic            dac_en,
  output logic            irq_n,
  output logic            wait_pull,
  output logic            bus_oe,
  inout  wire  [RW-1:0]   bus_io
);
  logic          rst_s1, rst_sync_n;
  logic [NIB-1:0] nib_code;
  logic          pass_done, tmr_restart, tmr_run;
  logic [RW-1:0] result;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  hfs_therm_enc #(.NLEV(NLEV)) u_enc (
    .therm (therm),
    .code  (nib_code)
  );

  hfs_pass_timer #(.PASS_CYC(PASS_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (tmr_restart),
    .run     (tmr_run),
    .done    (pass_done)
  );

  hfs_ctrl #(.NIB(NIB)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wrrd_mode   (wrrd_mode),
    .cs_n        (cs_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .nib_code    (nib_code),
    .pass_done   (pass_done),
    .tmr_restart (tmr_restart),
    .tmr_run     (tmr_run),
    .dac_code    (dac_code),
    .dac_en      (dac_en),
    .result      (result),
    .irq_n       (irq_n),
    .wait_pull   (wait_pull),
    .bus_oe      (bus_oe)
  );

  assign bus_io = bus_oe ? result : {RW{1'bz}};
endmodule

// File: tb/hfs_top_bench.sv
module hfs_top_bench;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrrd_mode = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [14:0] therm;
  logic [3:0]  dac_code;
  logic        dac_en, irq_n, wait_pull, bus_oe;
  wire  [7:0]  bus_io;

  logic [7:0]  vin = 8'h00;
  bit          bubble = 1'b0;
  int          nchk = 0, nfail = 0;
  logic [7:0]  exp_q[$];

  always #5 clk = ~clk;

  hfs_top #(.NIB(4), .PASS_CYC(P)) u_hfs_top (
    .clk(clk), .rst_n(rst_n), .wrrd_mode(wrrd_mode), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .therm(therm), .dac_code(dac_code), .dac_en(dac_en),
    .irq_n(irq_n), .wait_pull(wait_pull), .bus_oe(bus_oe), .bus_io(bus_io)
  );

  // comparator bank model: coarse ladder or residue
  function automatic logic [14:0] thermo(int n, bit bub);
    logic [14:0] t;
    t = 15'((1 << n) - 1);
    if (bub && n > 0 && n < 15) begin
      t[n-1] = 1'b0;
      t[n]   = 1'b1;
    end
    return t;
  endfunction

  always_comb begin : cmp_model
    int r;
    if (dac_en) r = int'(vin) - 16 * int'(dac_code);
    else        r = int'(vin) >> 4;
    if (r < 0)  r = 0;
    if (r > 15) r = 15;
    therm = thermo(r, bubble);
  end

  task automatic chk(bit ok, string tag, int act, int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  // monitor: on each falling irq_n, wait for the bus and compare with queue head
  initial begin : monitor
    logic irq_last;
    bit   pending;
    irq_last = 1'b1;
    pending  = 1'b0;
    forever begin
      @(negedge clk);
      #2;
      if (irq_last && !irq_n) pending = 1'b1;
      irq_last = irq_n;
      if (pending && bus_oe) begin
        pending = 1'b0;
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected result", int'(bus_io), 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(bus_io == e, "R3 result on bus", int'(bus_io), int'(e));
        end
      end
    end
  end

  // read-strobe conversion (R4, R5, R9)
  task automatic rd_conv(logic [7:0] v, bit bub);
    vin = v; bubble = bub; wrrd_mode = 1'b0;
    exp_q.push_back(v);
    cs_n = 1'b0; rd_n = 1'b0;
    for (int k = 1; k <= 2 * P + 1; k++) begin
      cyc();
      if (k == 1) chk(wait_pull == 1'b1, "R5 wait pulled after cs fall", wait_pull, 1);
      if (k == 2) chk(bus_oe == 1'b0, "R9 bus released during conversion", bus_oe, 0);
      if (k == 2 * P) chk(irq_n == 1'b1, "R4 irq still high", irq_n, 1);
      if (k == 2 * P + 1) begin
        chk(irq_n == 1'b0, "R4 irq low at end", irq_n, 0);
        chk(wait_pull == 1'b0, "R5 wait released", wait_pull, 0);
      end
    end
    cyc(2);
    rd_n = 1'b1;
    cyc();
    chk(irq_n == 1'b1, "R8 irq released by rd rise", irq_n, 1);
    cs_n = 1'b1;
    cyc();
  endtask

  // write, wait for interrupt, then read (R6, R3, R8)
  task automatic wr_conv(logic [7:0] v);
    vin = v; bubble = 1'b0; wrrd_mode = 1'b1;
    exp_q.push_back(v);
    cs_n = 1'b0; wr_n = 1'b0;
    cyc(P + 3);
    chk(dac_en == 1'b0 && irq_n == 1'b1, "R6 hold while wr low", dac_en, 0);
    wr_n = 1'b1;
    for (int k = 1; k <= P + 1; k++) begin
      cyc();
      if (k == 1) chk(dac_en == 1'b1 && dac_code == v[7:4], "R3 residue select", int'(dac_code), int'(v[7:4]));
      if (k == P) chk(irq_n == 1'b1, "R6 irq high before fine end", irq_n, 1);
      if (k == P + 1) chk(irq_n == 1'b0, "R6 irq low after fine pass", irq_n, 0);
    end
    rd_n = 1'b0;
    cyc(2);
    cs_n = 1'b1;
    cyc();
    chk(irq_n == 1'b1, "R8 irq released by cs rise", irq_n, 1);
    chk(bus_oe == 1'b0, "R9 bus released with cs high", bus_oe, 0);
    rd_n = 1'b1;
    cyc();
  endtask

  // write then early read (R7)
  task automatic er_conv(logic [7:0] v);
    vin = v; bubble = 1'b0; wrrd_mode = 1'b1;
    exp_q.push_back(v);
    cs_n = 1'b0; wr_n = 1'b0;
    cyc(P + 2);
    wr_n = 1'b1;
    cyc();
    chk(irq_n == 1'b1, "R7 irq high before early read", irq_n, 1);
    rd_n = 1'b0;
    cyc();
    chk(irq_n == 1'b0, "R7 early read ends conversion", irq_n, 0);
    cyc();
    rd_n = 1'b1;
    cyc();
    cs_n = 1'b1;
    cyc();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin : main
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    chk(irq_n == 1'b1, "R1 reset irq", irq_n, 1);
    chk(wait_pull == 1'b0, "R1 reset wait", wait_pull, 0);
    chk(dac_en == 1'b0, "R1 reset dac_en", dac_en, 0);
    chk(bus_oe == 1'b0, "R1 reset bus", bus_oe, 0);

    rd_conv(8'hA5, 1'b0);
    rd_conv(8'h00, 1'b0);
    rd_conv(8'hFF, 1'b0);
    rd_conv(8'h3C, 1'b0);
    rd_conv(8'h5A, 1'b1);   // R2 bubbled thermometer words
    rd_conv(8'h96, 1'b1);   // R2

    // R4: write pulse in read mode starts nothing
    wrrd_mode = 1'b0; cs_n = 1'b0; cyc();
    wr_n = 1'b0; cyc(2); wr_n = 1'b1;
    cyc(2 * P + 3);
    chk(irq_n == 1'b1 && dac_en == 1'b0, "R4 wr ignored in read mode", irq_n, 1);
    chk(bus_oe == 1'b0, "R9 bus released with rd high", bus_oe, 0);
    cs_n = 1'b1; cyc();

    // R4: read strobe with cs high starts nothing
    rd_n = 1'b0;
    cyc(2 * P + 3);
    chk(irq_n == 1'b1, "R4 rd ignored with cs high", irq_n, 1);
    chk(bus_oe == 1'b0, "R9 bus released with cs high", bus_oe, 0);
    rd_n = 1'b1; cyc();

    wr_conv(8'hC3);
    wr_conv(8'h1E);
    er_conv(8'h7B);
    er_conv(8'hE0);

    // R10: stand-alone, cs and rd held low
    wrrd_mode = 1'b1; vin = 8'h4D;
    exp_q.push_back(8'h4D);
    cs_n = 1'b0; cyc(); rd_n = 1'b0; cyc();
    wr_n = 1'b0; cyc(P + 2); wr_n = 1'b1; cyc(P + 4);
    vin = 8'hB2;
    exp_q.push_back(8'hB2);
    wr_n = 1'b0;
    cyc();
    chk(bus_io == 8'h4D, "R10 prior result at wr fall", int'(bus_io), 'h4D);
    chk(irq_n == 1'b1, "R8 irq released at new start", irq_n, 1);
    cyc(P + 1);
    chk(bus_io == 8'h4D, "R10 prior result while wr low", int'(bus_io), 'h4D);
    wr_n = 1'b1;
    cyc(P + 4);
    rd_n = 1'b1; cyc(); cs_n = 1'b1; cyc(3);

    chk(exp_q.size() == 0, "R3 all results observed", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule